// File: doc/BRIEF.md
# Dual-Context Byte DMA Engine for a Parallel Port

This block is a single DMA channel that moves bytes between system memory and a parallel-port device. Software loads up to two buffer descriptors, called context A and context B. Each descriptor gives a base address, a byte length and a "last" flag. Software then marks descriptors valid through a control word. The engine works through whichever context is valid, one at a time, and alternates between them. This lets software refill one buffer while the other drains.

Software reaches the engine through a small register port. That port has four 64-bit words: the two contexts, a control/status word and a read-only diagnostic word. Memory is reached through a byte-wide request/acknowledge interface. The device side is a byte-wide valid/ready handshake in each direction, plus a terminal-count strobe. The engine can be frozen in place and resumed. A reset bit returns the whole channel to its empty state.

Top module: `pdma_engine`

## Requirements
- R1: Register word 0 is context A and word 1 is context B. A context stores the base address in bits 31:0, the byte length in bits 43:32 and the last flag in bit 63. A context reads back as written until a channel reset clears it.
- R2: Register word 2 is control/status with these bits: bit 0 direction (0 = memory to device, 1 = device to memory), bit 1 enable, bit 2 channel reset, bit 3 context B valid, bit 4 context A valid, bit 5 sticky descriptor error (read-only). Bits 0 to 4 read back as written, except where the engine clears a valid bit.
- R3: In memory-to-device mode, the engine reads addresses base through base+len-1 in ascending order. It hands each byte to the device in that same order, one device handshake per byte.
- R4: In device-to-memory mode, the engine accepts len bytes from the device. It writes them in arrival order to ascending addresses starting at base.
- R5: After a channel reset, the engine serves context A first. When a buffer finishes, it clears that context's valid bit and moves to the other context if that one is valid; otherwise it waits until a valid bit is set.
- R6: If a context's last flag is set, the terminal-count output pulses high for exactly one cycle after the buffer's final byte is handled. A context with the flag clear produces no pulse.
- R7: A descriptor whose page offset (base bits 11:0) plus length exceeds 4096 moves no bytes. It sets the error bit, produces no terminal count and has its valid bit cleared.
- R8: In device-to-memory mode, a base whose bits 5:0 are not all zero is treated as a descriptor error, as in R7. In memory-to-device mode, any byte alignment is accepted.
- R9: While enable is 0, the engine issues no memory request and no device handshake. It keeps its address, remaining count and position. Setting enable again resumes the buffer where it stopped.
- R10: While the reset bit is 1, the engine idles. Both contexts, both valid bits, the error bit, the remaining count and the in-use context are cleared to zero.
- R11: Register word 3 is read-only diagnostics: bit 0 is the in-use context (0 = A, 1 = B), bit 1 is high while the engine is enabled and working on a buffer, and bits 13:2 hold the bytes still to move in the current buffer.
- R12: A valid descriptor with length 0 completes without any byte transfer. It still clears its valid bit, and it gives a terminal-count pulse if its last flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write to memory, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 8 | Byte written to memory |
| mem_ack | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | 8 | Byte read from memory, valid with mem_ack |
| dev_out_valid | output | 1 | Byte offered to the device |
| dev_out_data | output | 8 | Byte offered to the device |
| dev_out_ready | input | 1 | Device takes the offered byte |
| dev_in_valid | input | 1 | Device offers a byte |
| dev_in_data | input | 8 | Byte from the device |
| dev_in_ready | output | 1 | Engine takes the device byte |
| dev_tc | output | 1 | Terminal-count strobe to the device |

## Verification
The bench builds the engine with its default parameters: 32-bit addresses, 12-bit lengths, 4 KiB pages and 64-byte input alignment. These defaults are small enough that the page-end arithmetic can be swept directly. A series of buffers with lengths 1 to 8 is placed so that each one ends exactly at a page end, or one byte short of it. The contexts alternate, and the memory and device stall patterns vary from cycle to cycle. Expected addresses, byte values and terminal-count counts all follow from the base and length by simple arithmetic. The sweep also covers the one-byte page overrun, misaligned inbound bases, zero lengths, freezing mid-buffer and resetting mid-buffer.

// File: rtl/pdma_engine.sv
module pdma_engine #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 12,
  parameter int PAGE_W  = 12,
  parameter int ALIGN_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic        mem_ack,
  input  logic [7:0]  mem_rdata,
  output logic        dev_out_valid,
  output logic [7:0]  dev_out_data,
  input  logic        dev_out_ready,
  input  logic        dev_in_valid,
  input  logic [7:0]  dev_in_data,
  output logic        dev_in_ready,
  output logic        dev_tc
);
  localparam int LEN_LO = 32;
  localparam int LAST_B = 63;
  localparam int SPAN_W = (LEN_W > PAGE_W ? LEN_W : PAGE_W) + 1;
  localparam logic [SPAN_W-1:0] PAGE_SIZE = SPAN_W'(1) << PAGE_W;

  typedef enum logic [1:0] {S_IDLE, S_MEM, S_DEV, S_FIN} state_t;

  state_t            st;
  logic [63:0]       ctx_a, ctx_b;
  logic              ctl_dir, ctl_en, ctl_rst, err;
  logic [1:0]        vld;
  logic              cur, xdir, last;
  logic [ADDR_W-1:0] addr;
  logic [LEN_W-1:0]  cnt;
  logic [7:0]        byte_q;

  wire  [63:0]       sel      = cur ? ctx_b : ctx_a;
  wire  [ADDR_W-1:0] sel_base = sel[ADDR_W-1:0];
  wire  [LEN_W-1:0]  sel_len  = sel[LEN_LO +: LEN_W];
  wire  [SPAN_W-1:0] span     = SPAN_W'(sel_base[PAGE_W-1:0]) + SPAN_W'(sel_len);
  wire               bad      = (span > PAGE_SIZE) || (ctl_dir && |sel_base[ALIGN_W-1:0]);
  wire               run      = ctl_en && !ctl_rst;
  wire               nxt_cur  = vld[~cur] ? ~cur : cur;
  wire               at_end   = (cnt == LEN_W'(1));
  logic unused_bits;
  assign unused_bits = ^{sel[62:LEN_LO+LEN_W], sel[31:ADDR_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ctx_a <= '0; ctx_b <= '0;
      ctl_dir <= 1'b0; ctl_en <= 1'b0; ctl_rst <= 1'b0; err <= 1'b0; vld <= '0;
      cur <= 1'b0; xdir <= 1'b0; last <= 1'b0; addr <= '0; cnt <= '0; byte_q <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          2'd0: ctx_a <= reg_wdata;
          2'd1: ctx_b <= reg_wdata;
          2'd2: begin
            ctl_dir <= reg_wdata[0];
            ctl_en  <= reg_wdata[1];
            ctl_rst <= reg_wdata[2];
            vld     <= {reg_wdata[3], reg_wdata[4]};
          end
          default: ;
        endcase
      end
      if (ctl_rst) begin
        st <= S_IDLE; ctx_a <= '0; ctx_b <= '0; vld <= '0; err <= 1'b0;
        cur <= 1'b0; cnt <= '0; last <= 1'b0;
      end else if (ctl_en) begin
        case (st)
          S_IDLE:
            if (vld[cur]) begin
              if (bad) begin
                err      <= 1'b1;
                vld[cur] <= 1'b0;
                cur      <= nxt_cur;
              end else begin
                addr <= sel_base;
                cnt  <= sel_len;
                last <= sel[LAST_B];
                xdir <= ctl_dir;
                st   <= (sel_len == '0) ? S_FIN : (ctl_dir ? S_DEV : S_MEM);
              end
            end else if (vld[~cur]) begin
              cur <= ~cur;
            end
          S_MEM:
            if (mem_ack) begin
              if (!xdir) begin
                byte_q <= mem_rdata;
                st     <= S_DEV;
              end else begin
                addr <= addr + ADDR_W'(1);
                cnt  <= cnt - LEN_W'(1);
                st   <= at_end ? S_FIN : S_DEV;
              end
            end
          S_DEV:
            if (!xdir && dev_out_ready) begin
              addr <= addr + ADDR_W'(1);
              cnt  <= cnt - LEN_W'(1);
              st   <= at_end ? S_FIN : S_MEM;
            end else if (xdir && dev_in_valid) begin
              byte_q <= dev_in_data;
              st     <= S_MEM;
            end
          S_FIN: begin
            vld[cur] <= 1'b0;
            cur      <= nxt_cur;
            st       <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign mem_req       = run && st == S_MEM;
  assign mem_we        = xdir;
  assign mem_addr      = addr;
  assign mem_wdata     = byte_q;
  assign dev_out_valid = run && st == S_DEV && !xdir;
  assign dev_out_data  = byte_q;
  assign dev_in_ready  = run && st == S_DEV && xdir;
  assign dev_tc        = run && st == S_FIN && last;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ctx_a;
      2'd1:    reg_rdata = ctx_b;
      2'd2:    reg_rdata = 64'({err, vld[0], vld[1], ctl_rst, ctl_en, ctl_dir});
      default: reg_rdata = 64'({cnt, ctl_en && st != S_IDLE, cur});
    endcase
  end

  a_r6_tc_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dev_tc |=> !dev_tc);
  a_r9_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !ctl_rst) |=> ($stable(cnt) && $stable(addr) && $stable(st) && $stable(cur)));
  a_r10_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rst |=> (st == S_IDLE && vld == 2'b00 && cnt == '0 && !err));
  a_r3_count_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st != S_IDLE) && !$past(ctl_rst)) |-> (cnt <= $past(cnt)));
  a_r5_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, dev_out_valid, dev_in_ready, dev_tc}));
  a_r7_err_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (st == S_IDLE));
endmodule

// File: tb/test_pdma_engine.sv
`timescale 1ns/1ps
module test_pdma_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ack, dev_out_valid, dev_out_ready, dev_in_valid, dev_in_ready, dev_tc;
  logic [31:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata, dev_out_data, dev_in_data;
  logic [31:0] cyc = '0;
  logic [7:0] in_idx = '0;
  int checks = 0, errors = 0;
  int mon_err, rd_n, wr_n, out_n, tc_n;
  logic [31:0] rd_exp, wr_exp, out_exp;
  logic [7:0] wr_idx = '0;
  logic tc_prev = 1'b0;

  always #2.5 clk = ~clk;

  pdma_engine i_pdma_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
    .dev_tc(dev_tc));

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (dev_in_valid && dev_in_ready) in_idx <= in_idx + 8'd1;
  end
  assign mem_ack       = mem_req && (cyc % 3 != 0);
  assign mem_rdata     = pat(mem_addr);
  assign dev_out_ready = (cyc[0] == 1'b0);
  assign dev_in_valid  = (cyc[0] == 1'b1);
  assign dev_in_data   = 8'h30 + in_idx;

  always @(negedge clk) if (rst_n) begin
    if (mem_req && mem_ack && !mem_we) begin
      if (mem_addr != rd_exp) mon_err++;
      rd_exp++; rd_n++;
    end
    if (mem_req && mem_ack && mem_we) begin
      if (mem_addr != wr_exp || mem_wdata != 8'h30 + wr_idx) mon_err++;
      wr_exp++; wr_idx++; wr_n++;
    end
    if (dev_out_valid && dev_out_ready) begin
      if (dev_out_data != pat(out_exp)) mon_err++;
      out_exp++; out_n++;
    end
    if (dev_tc) begin
      tc_n++;
      if (tc_prev) mon_err++;
    end
    tc_prev = dev_tc;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [63:0] d);
    @(negedge clk); reg_addr = a; #0.5 d = reg_rdata;
  endtask

  function automatic logic [63:0] ctx(input logic [31:0] base, input int len, input bit lst);
    return {lst, 19'd0, 12'(len), base};
  endfunction

  function automatic logic [63:0] ctl(input bit dir, input bit en, input bit rs, input bit vb, input bit va);
    return 64'({va, vb, rs, en, dir});
  endfunction

  task automatic arm(input logic [31:0] base);
    @(posedge clk); #1;
    rd_exp = base; out_exp = base; wr_exp = base;
    rd_n = 0; wr_n = 0; out_n = 0; tc_n = 0; mon_err = 0;
  endtask

  task automatic wait_done();
    logic [63:0] c, d;
    for (int k = 0; k < 3000; k++) begin
      rreg(2'd2, c); rreg(2'd3, d);
      if (c[4:3] == 2'b00 && d[1] == 1'b0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic chan_reset();
    wreg(2'd2, ctl(0, 0, 1, 0, 0));
    wreg(2'd2, ctl(0, 0, 0, 0, 0));
  endtask

  initial begin
    logic [63:0] r, d0, d1;
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rreg(2'd2, r); check(r == 0, "R2 control after reset", r, 0);
    rreg(2'd3, r); check(r == 0, "R11 diag after reset", r, 0);
    check(dev_tc == 0 && mem_req == 0, "R10 outputs idle after reset", {dev_tc, mem_req}, 0);
    wreg(2'd0, 64'h8000_0123_dead_beef);
    rreg(2'd0, r); check(r == 64'h8000_0123_dead_beef, "R1 context A readback", r, 64'h8000_0123_dead_beef);
    wreg(2'd2, ctl(1, 0, 0, 0, 0));
    rreg(2'd2, r); check(r == 1, "R2 direction bit readback", r, 1);
    chan_reset();

    for (int i = 0; i < 8; i++) begin
      int len = i + 1;
      logic [31:0] base = 32'h0001_0000 + 32'(i) * 32'h1000 + 32'(4096 - len - (i % 2));
      bit lst = (i % 2 == 1);
      arm(base);
      wreg((i % 2 == 0) ? 2'd0 : 2'd1, ctx(base, len, lst));
      wreg(2'd2, ctl(0, 1, 0, i % 2 == 1, i % 2 == 0));
      wait_done();
      check(out_n == len && rd_n == len, "R3 byte count mem->dev", out_n, len);
      check(mon_err == 0, "R3 address/data order", mon_err, 0);
      check(tc_n == int'(lst), "R6 terminal count per last flag", tc_n, int'(lst));
      rreg(2'd3, r);
      check(r == 64'(i % 2), "R11 diag idle with context in use", r, i % 2);
      rreg(2'd2, r);
      check(r[4:3] == 0, "R5 valid cleared on completion", r[4:3], 0);
    end

    chan_reset();
    rreg(2'd0, r); check(r == 0, "R10 context cleared by reset", r, 0);
    rreg(2'd3, r); check(r == 0, "R10 diag cleared by reset", r, 0);
    arm(32'h3F00);
    wreg(2'd0, ctx(32'h3F00, 5, 0));
    wreg(2'd1, ctx(32'h3F05, 3, 1));
    wreg(2'd2, ctl(0, 1, 0, 1, 1));
    wait (out_n >= 1); @(posedge clk); #1;
    r = reg_rdata; reg_addr = 2'd3; #0.5 r = reg_rdata;
    check(r == 64'({12'd4, 1'b1, 1'b0}), "R11 diag mid-buffer on A", r, 64'({12'd4, 1'b1, 1'b0}));
    wait (out_n >= 6); @(posedge clk); #1;
    reg_addr = 2'd3; #0.5 r = reg_rdata;
    check(r == 64'({12'd2, 1'b1, 1'b1}), "R5 switched to context B", r, 64'({12'd2, 1'b1, 1'b1}));
    wait_done();
    check(out_n == 8 && mon_err == 0, "R5 A then B contiguous", out_n, 8);
    check(tc_n == 1, "R6 single pulse for last B only", tc_n, 1);

    chan_reset();
    arm(32'h5040);
    wreg(2'd0, ctx(32'h5040, 6, 1));
    wreg(2'd2, ctl(1, 1, 0, 0, 1));
    wait_done();
    check(wr_n == 6 && mon_err == 0, "R4 dev->mem writes", wr_n, 6);
    check(tc_n == 1, "R6 pulse after inbound buffer", tc_n, 1);

    arm(32'h5041);
    wreg(2'd1, ctx(32'h5041, 4, 1));
    wreg(2'd2, ctl(1, 1, 0, 1, 0));
    wait_done();
    rreg(2'd2, r);
    check(wr_n == 0 && tc_n == 0, "R8 misaligned inbound not moved", wr_n, 0);
    check(r[5] == 1 && r[4:3] == 0, "R8 error flagged, valid cleared", r, 64'h23);
    arm(32'h5041);
    wreg(2'd1, ctx(32'h5041, 4, 0));
    wreg(2'd2, ctl(0, 1, 0, 1, 0));
    wait_done();
    check(out_n == 4 && mon_err == 0, "R8 unaligned outbound accepted", out_n, 4);

    chan_reset();
    arm(32'h6FFC);
    wreg(2'd0, ctx(32'h6FFC, 5, 1));
    wreg(2'd2, ctl(0, 1, 0, 0, 1));
    wait_done();
    rreg(2'd2, r);
    check(out_n == 0 && rd_n == 0 && tc_n == 0, "R7 page overrun moves nothing", out_n + tc_n, 0);
    check(r[5] == 1 && r[4:3] == 0, "R7 error bit set", r[5], 1);

    chan_reset();
    arm(32'h7000);
    wreg(2'd0, ctx(32'h7000, 10, 1));
    wreg(2'd2, ctl(0, 1, 0, 0, 1));
    wait (out_n >= 3);
    wreg(2'd2, ctl(0, 0, 0, 0, 1));
    c0 = out_n + rd_n; rreg(2'd3, d0);
    repeat (40) @(negedge clk);
    rreg(2'd3, d1);
    check(out_n + rd_n == c0 && tc_n == 0, "R9 no traffic while frozen", out_n + rd_n, c0);
    check(d1 == d0 && d1[1] == 0, "R9 state held while frozen", d1, d0);
    wreg(2'd2, ctl(0, 1, 0, 0, 1));
    wait_done();
    check(out_n == 10 && mon_err == 0 && tc_n == 1, "R9 resume completes buffer", out_n, 10);

    arm(32'h8000);
    wreg(2'd0, ctx(32'h8000, 0, 1));
    wreg(2'd1, ctx(32'h8100, 0, 0));
    wreg(2'd2, ctl(0, 1, 0, 1, 1));
    wait_done();
    rreg(2'd2, r);
    check(out_n == 0 && tc_n == 1 && r[4:3] == 0, "R12 zero-length pair", tc_n, 1);

    chan_reset();
    arm(32'h9000);
    wreg(2'd0, ctx(32'h9000, 20, 1));
    wreg(2'd2, ctl(0, 1, 0, 0, 1));
    wait (out_n >= 2);
    wreg(2'd2, ctl(0, 1, 1, 0, 1));
    c0 = out_n;
    repeat (30) @(negedge clk);
    rreg(2'd0, r); check(r == 0, "R10 mid-buffer reset clears context", r, 0);
    rreg(2'd2, r); check(r == 64'h6, "R10 valid cleared by reset", r, 64'h6);
    rreg(2'd3, d0); check(d0 == 0, "R10 diag cleared mid-buffer", d0, 0);
    check(out_n == c0 && tc_n == 0, "R10 no traffic during reset", out_n, c0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule